// File: doc/BRIEF.md
# Index Pulse Conditioner with Position Capture

This block handles the zero (index) channel of an incremental encoder interpolator. A signed, already conditioned zero-channel sample arrives every clock. The block compares it against four times a programmable signed threshold, which gives an internal gating window. When the window opens in the same cycle as an AB output edge, the block starts a Z output pulse. The pulse lasts a programmable number of further AB output edges, and a new pulse cannot start until the current one has finished.

On a selectable event the block latches the 24-bit position word, which is the multi-cycle count joined with the fine angle. The event is either the start of Z or the opening of the gating window, and each capture comes with a one-cycle valid strobe. The block can also issue a one-cycle clear request to the multi-cycle counter whenever Z starts. A separate flag reports a pulse-width setting that is not below the interpolation factor. The AB edge strobe is taken to mark edges after any post-divider, so the pulse width is counted directly in strobes.

Top module: `zidx_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `z_o`, `win_o`, `cap_vld_o`, `cnt_clr_o`, `cfg_err_o` and `cap_pos_o` are all zero.
- R2: One clock after a sample is presented, `win_o` is 1 exactly when the signed sample is strictly greater than 4 × the signed 6-bit threshold. The threshold range is −32..+31.
- R3: Z starts only in a cycle where `ab_edge_i` is 1 and the sample opens the window while `win_o` is still 0. `z_o` rises on the same clock edge as `win_o`. If the window opens without an AB edge, no pulse starts while it stays open.
- R4: Once Z has started, `z_o` falls on the clock edge of the (width+1)-th following cycle that has `ab_edge_i` = 1. The width field is 4 bits.
- R5: While `z_o` is 1, a new window opening that coincides with an AB edge does not restart the pulse or extend it.
- R6: When `cfg_cap_sel_i` = 0, `cap_pos_o` takes the value of `pos_i` from the cycle in which Z starts. `cap_vld_o` is 1 for exactly that one following cycle.
- R7: When `cfg_cap_sel_i` = 1, `cap_pos_o` takes the value of `pos_i` from the cycle in which the window opens, with a one-cycle `cap_vld_o`. No AB edge is needed for this capture.
- R8: When `cfg_clr_en_i` = 1, `cnt_clr_o` pulses for one cycle on the edge where Z starts. When `cfg_clr_en_i` = 0, it never pulses.
- R9: One clock after the inputs change, `cfg_err_o` is 1 exactly when the width field is greater than or equal to the interpolation factor `cfg_interp_i`.
- R10: A capture fires only on the rising edge of the selected event. Holding the window open, with or without AB edges, produces no further `cap_vld_o` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| samp_i | input | SAMP_W (10) | Signed conditioned zero-channel sample |
| ab_edge_i | input | 1 | One-cycle strobe per AB output edge |
| pos_i | input | POS_W (24) | Position word: multi-cycle count and fine angle |
| cfg_thr_i | input | THR_W (6) | Signed window threshold |
| cfg_width_i | input | WID_W (4) | Z pulse width field; the pulse spans width+1 AB edges |
| cfg_interp_i | input | INTER_W (8) | Interpolation factor, used for the width check |
| cfg_cap_sel_i | input | 1 | Capture event select: 0 = Z start, 1 = window opening |
| cfg_clr_en_i | input | 1 | 1 = request a counter clear on Z start |
| z_o | output | 1 | Z output pulse |
| win_o | output | 1 | Internal gating window |
| cap_pos_o | output | POS_W (24) | Latched position |
| cap_vld_o | output | 1 | One-cycle strobe for a new latched position |
| cnt_clr_o | output | 1 | One-cycle multi-cycle counter clear request |
| cfg_err_o | output | 1 | The width field is not below the interpolation factor |

## Verification
The comparator is tried with samples exactly at four times a positive threshold and one count above it, and the same pair with a negative threshold. These pairs separate a strict compare from a non-strict one, a ×4 scale from other scales, and a signed compare from an unsigned one. Z is driven with a window that opens with an AB edge, with one that opens without an edge, and with a second opening during a running pulse. These cases separate the start condition, the edge-counted length and the retrigger lockout. Each capture mode is run with distinct position words, and the window is held open through AB edges afterwards. The scoreboard then catches a missing capture, a wrong source cycle and a repeated capture. The clear enable is run at both settings.

// File: rtl/zidx_pkg.sv
package zidx_pkg;
  typedef enum logic {
    CAP_ON_Z   = 1'b0,
    CAP_ON_WIN = 1'b1
  } cap_sel_e;

  localparam int unsigned THR_SHIFT = 2;
endpackage

// File: rtl/zidx_win_cmp.sv
module zidx_win_cmp #(
  parameter int unsigned SAMP_W = 10,
  parameter int unsigned THR_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [SAMP_W-1:0] samp_i,
  input  logic signed [THR_W-1:0]  thr_i,
  output logic                     win_o,
  output logic                     rise_o
);
  import zidx_pkg::*;

  localparam int unsigned WIDE   = (SAMP_W > THR_W + THR_SHIFT) ? SAMP_W : THR_W + THR_SHIFT;
  localparam int unsigned CMP_W  = WIDE + 1;

  logic signed [CMP_W-1:0] samp_ext;
  logic signed [CMP_W-1:0] thr_ext;
  logic signed [CMP_W-1:0] lim;
  logic                    win_d;
  logic                    win_q;

  always_comb begin
    samp_ext = CMP_W'(samp_i);
    thr_ext  = CMP_W'(thr_i);
    lim      = thr_ext <<< THR_SHIFT;
    win_d    = (samp_ext > lim);
    rise_o   = win_d & ~win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  assign win_o = win_q;
endmodule

// File: rtl/zidx_pulse_gen.sv
module zidx_pulse_gen #(
  parameter int unsigned WID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ab_edge_i,
  input  logic             rise_i,
  input  logic [WID_W-1:0] width_i,
  output logic             z_o,
  output logic             start_o
);
  logic             z_q, z_d;
  logic [WID_W-1:0] rem_q, rem_d;
  logic             upd_en;

  always_comb begin
    start_o = rise_i & ab_edge_i & ~z_q;
    upd_en  = start_o | (z_q & ab_edge_i);
    z_d     = z_q;
    rem_d   = rem_q;
    if (start_o) begin
      z_d   = 1'b1;
      rem_d = width_i;
    end else if (z_q && ab_edge_i) begin
      if (rem_q == '0) z_d   = 1'b0;
      else             rem_d = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q   <= 1'b0;
      rem_q <= '0;
    end else if (upd_en) begin
      z_q   <= z_d;
      rem_q <= rem_d;
    end
  end

  assign z_o = z_q;
endmodule

// File: rtl/zidx_capture.sv
module zidx_capture #(
  parameter int unsigned POS_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_sel_i,
  input  logic             clr_en_i,
  input  logic             z_start_i,
  input  logic             win_rise_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [POS_W-1:0] cap_pos_o,
  output logic             cap_vld_o,
  output logic             cnt_clr_o
);
  import zidx_pkg::*;

  logic             cap_evt;
  logic             clr_d;
  logic [POS_W-1:0] pos_q;
  logic             vld_q;
  logic             clr_q;

  always_comb begin
    cap_evt = (cap_sel_e'(cap_sel_i) == CAP_ON_WIN) ? win_rise_i : z_start_i;
    clr_d   = z_start_i & clr_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos_q <= '0;
    else if (cap_evt) pos_q <= pos_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      vld_q <= cap_evt;
      clr_q <= clr_d;
    end
  end

  assign cap_pos_o = pos_q;
  assign cap_vld_o = vld_q;
  assign cnt_clr_o = clr_q;
endmodule

// File: rtl/zidx_unit.sv
module zidx_unit #(
  parameter int unsigned SAMP_W  = 10,
  parameter int unsigned THR_W   = 6,
  parameter int unsigned WID_W   = 4,
  parameter int unsigned INTER_W = 8,
  parameter int unsigned POS_W   = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [SAMP_W-1:0] samp_i,
  input  logic                     ab_edge_i,
  input  logic [POS_W-1:0]         pos_i,
  input  logic signed [THR_W-1:0]  cfg_thr_i,
  input  logic [WID_W-1:0]         cfg_width_i,
  input  logic [INTER_W-1:0]       cfg_interp_i,
  input  logic                     cfg_cap_sel_i,
  input  logic                     cfg_clr_en_i,
  output logic                     z_o,
  output logic                     win_o,
  output logic [POS_W-1:0]         cap_pos_o,
  output logic                     cap_vld_o,
  output logic                     cnt_clr_o,
  output logic                     cfg_err_o
);
  localparam int unsigned CHK_W = ((WID_W > INTER_W) ? WID_W : INTER_W) + 1;

  logic win_rise;
  logic z_start;
  logic err_d, err_q;

  zidx_win_cmp #(.SAMP_W(SAMP_W), .THR_W(THR_W)) u_cmp (
    .clk    (clk),
    .rst_n  (rst_n),
    .samp_i (samp_i),
    .thr_i  (cfg_thr_i),
    .win_o  (win_o),
    .rise_o (win_rise)
  );

  zidx_pulse_gen #(.WID_W(WID_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .ab_edge_i (ab_edge_i),
    .rise_i    (win_rise),
    .width_i   (cfg_width_i),
    .z_o       (z_o),
    .start_o   (z_start)
  );

  zidx_capture #(.POS_W(POS_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_sel_i  (cfg_cap_sel_i),
    .clr_en_i   (cfg_clr_en_i),
    .z_start_i  (z_start),
    .win_rise_i (win_rise),
    .pos_i      (pos_i),
    .cap_pos_o  (cap_pos_o),
    .cap_vld_o  (cap_vld_o),
    .cnt_clr_o  (cnt_clr_o)
  );

  always_comb begin
    err_d = (CHK_W'(cfg_width_i) >= CHK_W'(cfg_interp_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign cfg_err_o = err_q;
endmodule

// File: rtl/zidx_chk.sv
module zidx_chk #(
  parameter int unsigned POS_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ab_edge_i,
  input logic [POS_W-1:0] pos_i,
  input logic             cfg_cap_sel_i,
  input logic             cfg_clr_en_i,
  input logic             z_o,
  input logic             win_o,
  input logic [POS_W-1:0] cap_pos_o,
  input logic             cap_vld_o,
  input logic             cnt_clr_o
);
  p_z_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_o) |-> $rose(win_o) && $past(ab_edge_i));

  p_z_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(z_o) |-> $past(ab_edge_i));

  p_cap_on_z_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(z_o) && !$past(cfg_cap_sel_i) |-> cap_vld_o && (cap_pos_o == $past(pos_i)));

  p_cap_on_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) && $past(cfg_cap_sel_i) |-> cap_vld_o && (cap_pos_o == $past(pos_i)));

  p_clr_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr_o |-> $rose(z_o) && $past(cfg_clr_en_i));

  p_vld_edge_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld_o |-> ($rose(z_o) || $rose(win_o)));
endmodule

bind zidx_unit zidx_chk #(.POS_W(POS_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ab_edge_i     (ab_edge_i),
  .pos_i         (pos_i),
  .cfg_cap_sel_i (cfg_cap_sel_i),
  .cfg_clr_en_i  (cfg_clr_en_i),
  .z_o           (z_o),
  .win_o         (win_o),
  .cap_pos_o     (cap_pos_o),
  .cap_vld_o     (cap_vld_o),
  .cnt_clr_o     (cnt_clr_o)
);

// File: tb/tb_zidx_unit.sv
module tb_zidx_unit;
  logic               clk;
  logic               rst_n;
  logic signed [9:0]  samp;
  logic               ab;
  logic [23:0]        pos;
  logic signed [5:0]  thr;
  logic [3:0]         wid;
  logic [7:0]         interp;
  logic               cap_sel;
  logic               clr_en;
  logic               z, win, vld, clr, err;
  logic [23:0]        cap_pos;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [23:0] exp_q[$];

  zidx_unit dut (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .ab_edge_i(ab), .pos_i(pos),
    .cfg_thr_i(thr), .cfg_width_i(wid), .cfg_interp_i(interp),
    .cfg_cap_sel_i(cap_sel), .cfg_clr_en_i(clr_en),
    .z_o(z), .win_o(win), .cap_pos_o(cap_pos), .cap_vld_o(vld),
    .cnt_clr_o(clr), .cfg_err_o(err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of inputs, then wait until the registered result is visible
  task automatic step(input int s, input logic a, input logic [23:0] p);
    samp = 10'(s);
    ab   = a;
    pos  = p;
    @(negedge clk);
  endtask

  // scoreboard driver side: record a capture the requirements predict
  task automatic expect_cap(input logic [23:0] p);
    exp_q.push_back(p);
  endtask

  // scoreboard monitor side
  always @(negedge clk) begin
    if (rst_n && !done && vld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected capture actual=%0h expected=none", cap_pos);
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        if (cap_pos !== e) begin
          errors++;
          $display("FAIL R6/R7 capture actual=%0h expected=%0h", cap_pos, e);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; samp = '0; ab = 1'b0; pos = '0; thr = 6'sd5; wid = 4'd2;
    interp = 8'd8; cap_sel = 1'b0; clr_en = 1'b1;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1 z", z, 0); check("R1 win", win, 0); check("R1 vld", vld, 0);
    check("R1 clr", clr, 0); check("R1 err", err, 0); check("R1 pos", cap_pos, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 z after release", z, 0);

    // R2: threshold +5 -> limit 20, strict compare
    step(20, 0, 0);  check("R2 at +limit", win, 0);
    step(21, 0, 0);  check("R2 above +limit", win, 1);
    check("R3 no edge no z", z, 0);
    step(0, 0, 0);   check("R2 drop", win, 0);
    thr = -6'sd3;    // limit -12
    step(-12, 0, 0); check("R2 at -limit", win, 0);
    step(-11, 0, 0); check("R2 above -limit", win, 1);
    step(-11, 1, 0); check("R3 held window no start", z, 0);
    step(-100, 0, 0); check("R2 negative low", win, 0);

    // R3/R4/R5/R6/R8: width 2, capture on Z, clear enabled
    thr = 6'sd5;
    expect_cap(24'h123456);
    step(100, 1, 24'h123456);
    check("R3 z rises with window", z, 1); check("R3 win", win, 1);
    check("R8 clr pulse", clr, 1);
    step(0, 0, 24'h1);    check("R8 clr one cycle", clr, 0); check("R4 z holds", z, 1);
    step(100, 1, 24'h2);  check("R5 no retrigger z", z, 1); check("R8 no clr", clr, 0);
    step(100, 1, 24'h3);  check("R4 z after 2 edges", z, 1);
    step(100, 1, 24'h4);  check("R4 z after 3 edges", z, 0);
    step(0, 0, 0);

    // R8: clear disabled; width 0 -> one edge
    clr_en = 1'b0; wid = 4'd0;
    expect_cap(24'hFEDCBA);
    step(50, 1, 24'hFEDCBA); check("R3 z", z, 1); check("R8 no clr when off", clr, 0);
    step(50, 0, 24'h5);      check("R4 w0 hold", z, 1);
    step(50, 1, 24'h6);      check("R4 w0 end", z, 0);
    step(0, 0, 0);

    // R7/R10: capture on window rise, no AB edge needed; hold open
    cap_sel = 1'b1;
    expect_cap(24'hABCDEF);
    step(60, 0, 24'hABCDEF); check("R7 win", win, 1); check("R7 no z", z, 0);
    step(60, 1, 24'h7);      check("R10 held no z", z, 0);
    step(60, 1, 24'h8);
    step(60, 0, 24'h9);
    step(0, 0, 0);

    // R9: width vs interpolation factor
    interp = 8'd3; wid = 4'd3;
    step(0, 0, 0); check("R9 equal flags", err, 1);
    wid = 4'd2;
    step(0, 0, 0); check("R9 below clear", err, 0);
    wid = 4'd15; interp = 8'd16;
    step(0, 0, 0); check("R9 max ok", err, 0);

    step(0, 0, 0);
    check("R6/R7 all captures seen", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule